// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with In-Service Tracking

This block gathers eight interrupt request lines and presents a single interrupt to a processor. Each line keeps a pending flag, a service flag and a mask flag. Requests are edge-sensitive. A rising edge on a line sets its pending flag, and the flag stays set until the processor acknowledges that line.

Line 0 has the highest priority and line 7 the lowest. The resolver walks the lines from 0 upward. It stops at the first line that is either pending and unmasked, or already in service. If that line is pending, the interrupt output is raised and the line number is presented as a 3-bit vector. If that line is in service, nothing is raised. A line in service therefore holds off every line at or below its own priority until software sends an end-of-interrupt. That command retires the highest-priority line that is in service.

Each line can hold one further request behind its own service, because its pending flag is separate from its service flag. Any extra edges that arrive while that flag is already set are lost.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, and no line is pending, in service or masked.
- R2: A rising edge on a request line sets that line's pending flag. A line that is held high produces only one request.
- R3: A pending flag stays set until its line is acknowledged. Lowering the request line does not clear it.
- R4: When the interrupt is raised, the vector gives, as a 3-bit binary number, the lowest-numbered line that is pending and unmasked. No higher-priority line may be in service at that time.
- R5: A masked line never raises the interrupt output, but its pending flag still latches. Unmasking the line later raises the interrupt.
- R6: An acknowledge while the interrupt is raised clears the winning line's pending flag and sets its service flag. An acknowledge while the interrupt is low changes nothing.
- R7: A line in service blocks its own line and every line with a higher number. A pending line with a lower number is still raised, so interrupts can nest.
- R8: End-of-interrupt clears the service flag with the lowest line number, and no other service flag.
- R9: While a line is in service, one new edge on that line is remembered. Further edges before that line is acknowledged again are lost.
- R10: A rising edge on a line in the same cycle as the acknowledge of that line leaves the line pending.
- R11: A mask write loads all eight mask flags from the data input. Bit i set to 1 masks line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqLines | input | 8 | Interrupt request lines, rising-edge sensitive |
| maskWrEn | input | 1 | Load the mask flags from maskWrData |
| maskWrData | input | 8 | New mask value; bit i = 1 masks line i |
| ackIn | input | 1 | Processor acknowledge of the raised interrupt |
| eoiIn | input | 1 | End-of-interrupt command |
| irqOut | output | 1 | Interrupt request to the processor |
| vectorOut | output | 3 | Number of the raised line; 0 when irqOut is low |

## Verification
The assertions check several rules on every cycle. A raised interrupt always points at a pending, unmasked line. No pending unmasked line or service flag sits above it in priority. Pending flags are cleared only by an acknowledge, and an acknowledge or an end-of-interrupt changes the number of service flags by exactly one. Some behaviour shows only across sequences, so the bench's scenarios cover it. These include the nesting order, the loss of a second buffered edge, the edge that coincides with an acknowledge, and a masked request that surfaces after unmasking.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LINES = 8;
  localparam int VEC_W = $clog2(LINES);

  // strobes from the resolver to the flag registers, one-hot or zero
  typedef struct packed {
    logic [LINES-1:0] ackSet;
    logic [LINES-1:0] eoiClr;
  } strobe_t;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] reqLines,
  input  logic             maskWrEn,
  input  logic [LINES-1:0] maskWrData,
  input  strobe_t          strobes,
  output logic [LINES-1:0] reqPend,
  output logic [LINES-1:0] inService,
  output logic [LINES-1:0] maskBits
);
  logic [LINES-1:0] prevReq;
  logic [LINES-1:0] reqRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevReq  <= '0;
      maskBits <= '0;
    end else begin
      prevReq <= reqLines;
      if (maskWrEn) maskBits <= maskWrData;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : gLine
    assign reqRise[i] = reqLines[i] & ~prevReq[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reqPend[i]   <= 1'b0;
        inService[i] <= 1'b0;
      end else begin
        // a new edge wins over the acknowledge of the same line
        if (reqRise[i])                reqPend[i] <= 1'b1;
        else if (strobes.ackSet[i])    reqPend[i] <= 1'b0;
        if (strobes.ackSet[i])         inService[i] <= 1'b1;
        else if (strobes.eoiClr[i])    inService[i] <= 1'b0;
      end
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes.ackSet)); // R6

  AST_PEND_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(reqPend) & ~$past(strobes.ackSet) & ~reqPend) == '0)); // R3

  AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.ackSet != '0 && strobes.eoiClr == '0)
    |=> $countones(inService) == $countones($past(inService)) + 1); // R6

  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.eoiClr != '0 && strobes.ackSet == '0)
    |=> $countones(inService) + 1 == $countones($past(inService))); // R8
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] reqPend,
  input  logic [LINES-1:0] inService,
  input  logic [LINES-1:0] maskBits,
  input  logic             ackIn,
  input  logic             eoiIn,
  output logic             irqOut,
  output logic [VEC_W-1:0] vectorOut,
  output strobe_t          strobes
);
  logic [LINES-1:0] eligible;
  logic             scanHit;
  logic             winIsReq;
  logic [VEC_W-1:0] winLine;
  logic             isrHit;
  logic [VEC_W-1:0] isrLine;

  assign eligible = reqPend & ~maskBits;

  // walk from line 0 upward; stop at first pending or in-service line
  always_comb begin
    scanHit  = 1'b0;
    winIsReq = 1'b0;
    winLine  = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!scanHit && (eligible[i] || inService[i])) begin
        scanHit  = 1'b1;
        winIsReq = !inService[i];
        winLine  = VEC_W'(i);
      end
    end
  end

  // highest-priority line in service, for end-of-interrupt
  always_comb begin
    isrHit  = 1'b0;
    isrLine = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!isrHit && inService[i]) begin
        isrHit  = 1'b1;
        isrLine = VEC_W'(i);
      end
    end
  end

  assign irqOut    = winIsReq;
  assign vectorOut = winIsReq ? winLine : '0;

  always_comb begin
    strobes = '0;
    if (ackIn && winIsReq) strobes.ackSet[winLine] = 1'b1;
    if (eoiIn && isrHit)   strobes.eoiClr[isrLine] = 1'b1;
  end

  AST_IRQ_POINTS_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (reqPend[vectorOut] && !maskBits[vectorOut])); // R5

  AST_NO_BETTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> ((eligible & ~({LINES{1'b1}} << vectorOut)) == '0)); // R4

  AST_NO_ISR_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> ((inService & ~({LINES{1'b1}} << (int'(vectorOut) + 1))) == '0)); // R7

  AST_IDLE_ACK_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && !irqOut) |-> (strobes.ackSet == '0)); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] reqLines,
  input  logic             maskWrEn,
  input  logic [LINES-1:0] maskWrData,
  input  logic             ackIn,
  input  logic             eoiIn,
  output logic             irqOut,
  output logic [VEC_W-1:0] vectorOut
);
  strobe_t          strobes;
  logic [LINES-1:0] reqPend;
  logic [LINES-1:0] inService;
  logic [LINES-1:0] maskBits;

  prio_irq_regs uRegs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqLines   (reqLines),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .strobes    (strobes),
    .reqPend    (reqPend),
    .inService  (inService),
    .maskBits   (maskBits)
  );

  prio_irq_resolve uResolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqPend   (reqPend),
    .inService (inService),
    .maskBits  (maskBits),
    .ackIn     (ackIn),
    .eoiIn     (eoiIn),
    .irqOut    (irqOut),
    .vectorOut (vectorOut),
    .strobes   (strobes)
  );
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqLines = '0;
  logic       maskWrEn = 1'b0;
  logic [7:0] maskWrData = '0;
  logic       ackIn = 1'b0;
  logic       eoiIn = 1'b0;
  logic       irqOut;
  logic [2:0] vectorOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reqLines(reqLines), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .ackIn(ackIn), .eoiIn(eoiIn),
    .irqOut(irqOut), .vectorOut(vectorOut)
  );

  // fields: req[22:15] ack[14] eoi[13] mwe[12] mdata[11:4] irq[3] vec[2:0]
  localparam int NSTEP = 17;
  localparam logic [22:0] STEPS [NSTEP] = '{
    {8'h04, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2}, // R2 line 2 rises
    {8'h04, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2}, // R3 held
    {8'h14, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2}, // R4 line 4 joins, 2 wins
    {8'h14, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // R6 R7 ack 2, blocks 4
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // R3 lines drop
    {8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd0}, // R7 line 0 nests
    {8'h01, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // R6 ack 0
    {8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0}, // R8 eoi retires 0, 2 still blocks
    {8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 3'd4}, // R8 eoi retires 2, 4 raised
    {8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // R6 ack 4
    {8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0}, // R8 idle
    {8'h00, 1'b0, 1'b0, 1'b1, 8'h08, 1'b0, 3'd0}, // R11 mask line 3
    {8'h08, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // R5 masked edge latches silently
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // R5
    {8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 3'd3}, // R5 R11 unmask raises 3
    {8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // R6 ack 3
    {8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0}  // R8 idle again
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] req, input logic ack, input logic eoi,
                      input logic mwe, input logic [7:0] mdata);
    @(negedge clk);
    reqLines = req; ackIn = ack; eoiIn = eoi; maskWrEn = mwe; maskWrData = mdata;
    @(posedge clk);
    #1;
    ackIn = 1'b0; eoiIn = 1'b0; maskWrEn = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic eIrq, input logic [2:0] eVec);
    chk({tag, " irq"}, int'(irqOut), int'(eIrq));
    if (eIrq) chk({tag, " vector"}, int'(vectorOut), int'(eVec));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 in reset", 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out("R1 after reset", 1'b0, 3'd0);

    for (int k = 0; k < NSTEP; k++) begin
      step(STEPS[k][22:15], STEPS[k][14], STEPS[k][13], STEPS[k][12], STEPS[k][11:4]);
      expect_out($sformatf("table step %0d", k), STEPS[k][3], STEPS[k][2:0]);
    end

    // R6: acknowledge with nothing raised is ignored
    step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    expect_out("R6 idle ack", 1'b0, 3'd0);
    step(8'h80, 1'b0, 1'b0, 1'b0, 8'h00);
    expect_out("R6 line 7 not blocked after idle ack", 1'b1, 3'd7);
    chk("R6 vector during ack", int'(vectorOut), 7);
    step(8'h80, 1'b1, 1'b0, 1'b0, 8'h00);
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_out("R8 line 7 retired", 1'b0, 3'd0);

    // R9: one edge buffered behind service, the next one lost
    step(8'h20, 1'b0, 1'b0, 1'b0, 8'h00);
    step(8'h20, 1'b1, 1'b0, 1'b0, 8'h00);
    expect_out("R9 line 5 in service", 1'b0, 3'd0);
    step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    step(8'h20, 1'b0, 1'b0, 1'b0, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    step(8'h20, 1'b0, 1'b0, 1'b0, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    expect_out("R9 held off while in service", 1'b0, 3'd0);
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_out("R9 buffered edge raised", 1'b1, 3'd5);
    step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_out("R9 third edge lost", 1'b0, 3'd0);

    // R10: edge coinciding with acknowledge of the same line
    step(8'h40, 1'b0, 1'b0, 1'b0, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    expect_out("R10 line 6 pending", 1'b1, 3'd6);
    step(8'h40, 1'b1, 1'b0, 1'b0, 8'h00);
    expect_out("R10 blocked by own service", 1'b0, 3'd0);
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_out("R10 coincident edge kept", 1'b1, 3'd6);
    step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_out("R10 drained", 1'b0, 3'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule